// File: doc/BRIEF.md
# Three-Port Latched Datapath Multiplexer

This block moves 9-bit words, where bit 8 carries parity, between three ports named A, B and C. A word from any one port can be sent to either of the other two ports or to both at once. Each port has a separate input bus, a separate output bus and a drive flag, so the block needs no tri-state logic. The surrounding logic ties each port to a shared pad or bus. Two select inputs and three active-low output enables choose the route.

There are four directional holding stages: A toward C, B toward C, C toward A and C toward B. Each stage is transparent while its latch enable is low and holds its word while the enable is high. Traffic between A and B passes through the C-side node, so it crosses two stages. A parity-invert control flips bit 8 of words that enter from port C, which lets a test force a parity error on A or B. A word held in a stage can be driven back onto the port it came from, so a test can read back a stored word after that port's input has changed.

The holding stages are clocked. The held word is the input present at the last rising clock edge at which the stage's enable was low. While the enable is low, the stage output follows its input in the same cycle with no register in the path.

Top module: `tri_port_mux`

## Requirements
- R1: The C output takes the word from the A-to-C stage when `selSrcB` is 0 and from the B-to-C stage when `selSrcB` is 1. This fixed priority applies even when both A and B could supply C.
- R2: The A output comes from the C-to-A stage and the B output comes from the C-to-B stage. Both stages take their input from port C's input when `selSrcC` is 1, and otherwise from the word that the R1 selection picks. This gives the routes A to B and B to A.
- R3: A stage whose enable is low passes its input to its output in the same cycle.
- R4: A stage whose enable is high outputs the word it captured at the last rising clock edge at which its enable was low. Changes on its input have no effect while the enable stays high.
- R5: When `selSrcC` is 1 and `parInv` is 1, bit 8 of the A and B outputs is the inverse of the stored or passed C bit 8, and bits 0 to 7 are unchanged. `parInv` has no effect when `selSrcC` is 0. The inversion acts at the stage output, so toggling `parInv` flips bit 8 of a held word at once.
- R6: Output enables are active low. A disabled port drives an all-zero output word and its drive flag is 0. An enabled port's drive flag is 1.
- R7: With both selects at 0, a word captured from A into the A-to-C and C-to-A stages appears on the A output once A is enabled and both stages hold. This readback ignores later changes on the A input.
- R8: While `rstN` is low, every stage is cleared to zero. Holding stages therefore read zero after reset until they capture a word.
- R9: With `selSrcC` at 1 and both A and B enabled, the C word goes to both A and B in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the holding stages |
| rstN | input | 1 | Active-low reset that clears all stages |
| selSrcB | input | 1 | Picks the B-to-C stage (1) or the A-to-C stage (0) as the C-side word |
| selSrcC | input | 1 | Makes port C the source for the A and B outputs |
| oeAN | input | 1 | Active-low output enable for port A |
| oeBN | input | 1 | Active-low output enable for port B |
| oeCN | input | 1 | Active-low output enable for port C |
| holdAC | input | 1 | Enable of the A-to-C stage; high holds |
| holdCA | input | 1 | Enable of the C-to-A stage; high holds |
| holdBC | input | 1 | Enable of the B-to-C stage; high holds |
| holdCB | input | 1 | Enable of the C-to-B stage; high holds |
| parInv | input | 1 | Inverts bit 8 on words sourced from C |
| aIn | input | 9 | Word arriving on port A |
| bIn | input | 9 | Word arriving on port B |
| cIn | input | 9 | Word arriving on port C |
| aOut | output | 9 | Word driven onto port A |
| bOut | output | 9 | Word driven onto port B |
| cOut | output | 9 | Word driven onto port C |
| aDrv | output | 1 | Port A is driving |
| bDrv | output | 1 | Port B is driving |
| cDrv | output | 1 | Port C is driving |

## Verification
Parity inversion and holding can act on the same word in the same cycle. The invert acts at the output of a C-to-A or C-to-B stage, so a held word must flip bit 8 when `parInv` toggles and keep every other bit. A directed case captures a C word, raises the hold, toggles `parInv` and compares both outputs. Random cycles then mix hold enables, selects and `parInv` freely. Each output is judged against a bench model that captures words only at edges where the enable is low.

// File: rtl/tpm_pkg.sv
package tpm_pkg;
  // Strobes passed from the control decode to the datapath
  typedef struct packed {
    logic cFromC;   // C input feeds the A/B-side stages
    logic pickB;    // C-side word taken from the B-to-C stage
    logic flipPar;  // invert parity bit on the A/B outputs
    logic drvA;
    logic drvB;
    logic drvC;
  } route_t;
endpackage

// File: rtl/tpm_ctrl.sv
module tpm_ctrl
  import tpm_pkg::*;
(
  input  logic   selSrcB,
  input  logic   selSrcC,
  input  logic   oeAN,
  input  logic   oeBN,
  input  logic   oeCN,
  input  logic   parInv,
  output route_t route
);
  always_comb begin
    route.cFromC  = selSrcC;
    route.pickB   = selSrcB;
    route.flipPar = selSrcC & parInv;
    route.drvA    = ~oeAN;
    route.drvB    = ~oeBN;
    route.drvC    = ~oeCN;
  end
endmodule

// File: rtl/tpm_hold_stage.sv
module tpm_hold_stage #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         hold,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] heldQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      heldQ <= '0;
    else if (!hold) heldQ <= d;
  end

  assign q = hold ? heldQ : d;
endmodule

// File: rtl/tpm_datapath.sv
module tpm_datapath
  import tpm_pkg::*;
#(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rstN,
  input  route_t       route,
  input  logic         holdAC,
  input  logic         holdCA,
  input  logic         holdBC,
  input  logic         holdCB,
  input  logic [W-1:0] aIn,
  input  logic [W-1:0] bIn,
  input  logic [W-1:0] cIn,
  output logic [W-1:0] aOut,
  output logic [W-1:0] bOut,
  output logic [W-1:0] cOut
);
  localparam int NSIDE = 2;  // index 0 = port A side, 1 = port B side
  localparam logic [W-1:0] PAR_MASK = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] sideIn   [NSIDE];
  logic         toCHold  [NSIDE];
  logic         frCHold  [NSIDE];
  logic         sideDrv  [NSIDE];
  logic [W-1:0] toCQ     [NSIDE];
  logic [W-1:0] frCQ     [NSIDE];
  logic [W-1:0] sideOut  [NSIDE];
  logic [W-1:0] cSideWord;
  logic [W-1:0] cNode;

  assign sideIn[0]  = aIn;
  assign sideIn[1]  = bIn;
  assign toCHold[0] = holdAC;
  assign toCHold[1] = holdBC;
  assign frCHold[0] = holdCA;
  assign frCHold[1] = holdCB;
  assign sideDrv[0] = route.drvA;
  assign sideDrv[1] = route.drvB;

  // C-side word: fixed priority by select
  assign cSideWord = route.pickB ? toCQ[1] : toCQ[0];
  assign cNode     = route.cFromC ? cIn : cSideWord;

  for (genvar i = 0; i < NSIDE; i++) begin : g_side
    tpm_hold_stage #(.W(W)) u_toC (
      .clk(clk), .rstN(rstN), .hold(toCHold[i]), .d(sideIn[i]), .q(toCQ[i])
    );
    tpm_hold_stage #(.W(W)) u_frC (
      .clk(clk), .rstN(rstN), .hold(frCHold[i]), .d(cNode), .q(frCQ[i])
    );
    assign sideOut[i] = sideDrv[i]
                      ? (frCQ[i] ^ (route.flipPar ? PAR_MASK : '0))
                      : '0;
  end

  assign aOut = sideOut[0];
  assign bOut = sideOut[1];
  assign cOut = route.drvC ? cSideWord : '0;
endmodule

// File: rtl/tri_port_mux.sv
module tri_port_mux
  import tpm_pkg::*;
#(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              selSrcB,
  input  logic              selSrcC,
  input  logic              oeAN,
  input  logic              oeBN,
  input  logic              oeCN,
  input  logic              holdAC,
  input  logic              holdCA,
  input  logic              holdBC,
  input  logic              holdCB,
  input  logic              parInv,
  input  logic [DATA_W-1:0] aIn,
  input  logic [DATA_W-1:0] bIn,
  input  logic [DATA_W-1:0] cIn,
  output logic [DATA_W-1:0] aOut,
  output logic [DATA_W-1:0] bOut,
  output logic [DATA_W-1:0] cOut,
  output logic              aDrv,
  output logic              bDrv,
  output logic              cDrv
);
  route_t route;

  tpm_ctrl u_ctrl (
    .selSrcB(selSrcB), .selSrcC(selSrcC),
    .oeAN(oeAN), .oeBN(oeBN), .oeCN(oeCN),
    .parInv(parInv), .route(route)
  );

  tpm_datapath #(.W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .route(route),
    .holdAC(holdAC), .holdCA(holdCA), .holdBC(holdBC), .holdCB(holdCB),
    .aIn(aIn), .bIn(bIn), .cIn(cIn),
    .aOut(aOut), .bOut(bOut), .cOut(cOut)
  );

  assign aDrv = route.drvA;
  assign bDrv = route.drvB;
  assign cDrv = route.drvC;
endmodule

// File: rtl/tpm_chk.sv
module tpm_chk #(
  parameter int DATA_W = 9
) (
  input logic              clk,
  input logic              rstN,
  input logic              selSrcB,
  input logic              selSrcC,
  input logic              oeAN,
  input logic              oeBN,
  input logic              oeCN,
  input logic              holdAC,
  input logic              holdCA,
  input logic              holdBC,
  input logic              holdCB,
  input logic              parInv,
  input logic [DATA_W-1:0] aIn,
  input logic [DATA_W-1:0] bIn,
  input logic [DATA_W-1:0] cIn,
  input logic [DATA_W-1:0] aOut,
  input logic [DATA_W-1:0] bOut,
  input logic [DATA_W-1:0] cOut,
  input logic              aDrv,
  input logic              bDrv,
  input logic              cDrv
);
  localparam logic [DATA_W-1:0] PBIT = {1'b1, {(DATA_W-1){1'b0}}};

  // R1
  c_from_b_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!selSrcC && selSrcB && !holdBC && !oeCN) |-> (cOut == bIn));

  // R3
  a_readthru_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!selSrcC && !selSrcB && !holdAC && !holdCA && !oeAN) |-> (aOut == aIn));

  // R4
  a_hold_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (holdCA && $past(holdCA) && !oeAN && !$past(oeAN)
     && $stable(selSrcC) && $stable(parInv)) |-> $stable(aOut));

  // R5
  b_parity_chk: assert property (@(posedge clk) disable iff (!rstN)
    (selSrcC && !holdCB && !oeBN) |-> (bOut == (cIn ^ (parInv ? PBIT : '0))));

  // R6
  b_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    oeBN |-> (bOut == '0 && !bDrv));

  // R6
  c_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    oeCN |-> (cOut == '0 && !cDrv));

  // R9
  broadcast_chk: assert property (@(posedge clk) disable iff (!rstN)
    (selSrcC && !holdCA && !holdCB && !oeAN && !oeBN) |-> (aOut == bOut && aDrv && bDrv));
endmodule

bind tri_port_mux tpm_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .selSrcB(selSrcB), .selSrcC(selSrcC),
  .oeAN(oeAN), .oeBN(oeBN), .oeCN(oeCN),
  .holdAC(holdAC), .holdCA(holdCA), .holdBC(holdBC), .holdCB(holdCB),
  .parInv(parInv), .aIn(aIn), .bIn(bIn), .cIn(cIn),
  .aOut(aOut), .bOut(bOut), .cOut(cOut),
  .aDrv(aDrv), .bDrv(bDrv), .cDrv(cDrv)
);

// File: tb/tri_port_mux_tb.sv
module tri_port_mux_tb;
  localparam int W = 9;
  localparam logic [W-1:0] PBIT = 9'h100;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic selSrcB = 0, selSrcC = 0, oeAN = 1, oeBN = 1, oeCN = 1;
  logic holdAC = 1, holdCA = 1, holdBC = 1, holdCB = 1, parInv = 0;
  logic [W-1:0] aIn = '0, bIn = '0, cIn = '0;
  logic [W-1:0] aOut, bOut, cOut;
  logic aDrv, bDrv, cDrv;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  tri_port_mux #(.DATA_W(W)) u_dut (
    .clk(clk), .rstN(rstN), .selSrcB(selSrcB), .selSrcC(selSrcC),
    .oeAN(oeAN), .oeBN(oeBN), .oeCN(oeCN),
    .holdAC(holdAC), .holdCA(holdCA), .holdBC(holdBC), .holdCB(holdCB),
    .parInv(parInv), .aIn(aIn), .bIn(bIn), .cIn(cIn),
    .aOut(aOut), .bOut(bOut), .cOut(cOut),
    .aDrv(aDrv), .bDrv(bDrv), .cDrv(cDrv)
  );

  // Reference stage contents, captured per R4/R8
  logic [W-1:0] mAC = '0, mBC = '0, mCA = '0, mCB = '0;

  function automatic logic [W-1:0] stage(input logic hold, input logic [W-1:0] held,
                                         input logic [W-1:0] d);
    return hold ? held : d;
  endfunction

  function automatic logic [W-1:0] expCSide();
    return selSrcB ? stage(holdBC, mBC, bIn) : stage(holdAC, mAC, aIn);
  endfunction

  function automatic logic [W-1:0] expNode();
    return selSrcC ? cIn : expCSide();
  endfunction

  function automatic logic [W-1:0] expSide(input logic oeN, input logic hold,
                                           input logic [W-1:0] held);
    logic [W-1:0] v;
    v = stage(hold, held, expNode());
    if (selSrcC && parInv) v = v ^ PBIT;
    return oeN ? '0 : v;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mAC <= '0; mBC <= '0; mCA <= '0; mCB <= '0;
    end else begin
      if (!holdAC) mAC <= aIn;
      if (!holdBC) mBC <= bIn;
      if (!holdCA) mCA <= expNode();
      if (!holdCB) mCB <= expNode();
    end
  end

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic checkModel(input string tagA, input string tagC);
    check(tagA, aOut, expSide(oeAN, holdCA, mCA));
    check(tagA, bOut, expSide(oeBN, holdCB, mCB));
    check(tagC, cOut, oeCN ? '0 : expCSide());
    check("R6 drive flags", {6'd0, aDrv, bDrv, cDrv}, {6'd0, ~oeAN, ~oeBN, ~oeCN});
  endtask

  task automatic nextCycle();
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0077));
    oeAN = 0; oeBN = 0; oeCN = 0;
    repeat (3) @(negedge clk);
    #5;
    // R8: held stages read zero during reset
    check("R8 reset A", aOut, '0);
    check("R8 reset C", cOut, '0);
    rstN = 1;
    nextCycle(); #5;
    check("R8 after reset B", bOut, '0);

    // R1: C picks A-side when selSrcB=0
    nextCycle();
    holdAC = 0; holdBC = 0; aIn = 9'h0AB; bIn = 9'h123; selSrcB = 0; selSrcC = 0;
    #5 check("R1 C from A", cOut, 9'h0AB);
    // R2: A to B through the C node (C-to-B transparent)
    holdCB = 0;
    #1 check("R2 A to B", bOut, 9'h0AB);
    nextCycle();
    selSrcB = 1; holdCA = 0; parInv = 1;
    #5 check("R1 C from B", cOut, 9'h123);
    // R5: parInv ignored when C is not the source; R2 B to A
    check("R5 no invert B to A", aOut, 9'h123);
    nextCycle();
    // R4: hold B-to-C, change bIn; C keeps captured word
    holdBC = 1; bIn = 9'h1FF;
    #5 check("R4 hold keeps word", cOut, 9'h123);
    nextCycle(); #5;
    check("R4 hold still", cOut, 9'h123);

    // R7: readback of A
    nextCycle();
    parInv = 0; selSrcB = 0; selSrcC = 0; oeAN = 1; oeCN = 1;
    holdAC = 0; holdCA = 0; aIn = 9'h1A5;
    #5 check("R6 A disabled", aOut, '0);
    check("R6 A flag low", {8'd0, aDrv}, 9'd0);
    nextCycle();
    holdAC = 1; holdCA = 1; aIn = 9'h05A; oeAN = 0;
    #5 check("R7 readback A", aOut, 9'h1A5);
    nextCycle(); #5;
    check("R7 readback A stays", aOut, 9'h1A5);

    // R3 transparent readback path
    nextCycle();
    holdAC = 0; holdCA = 0;
    #5 check("R3 transparent", aOut, 9'h05A);

    // R5 + R9: C broadcast with parity invert
    nextCycle();
    selSrcC = 1; parInv = 1; holdCA = 0; holdCB = 0; oeAN = 0; oeBN = 0; cIn = 9'h0F3;
    #5 check("R5 R9 A invert", aOut, 9'h1F3);
    check("R9 B broadcast", bOut, 9'h1F3);
    parInv = 0;
    #1 check("R5 no invert", aOut, 9'h0F3);
    cIn = 9'h1F3; parInv = 1;
    #1 check("R5 invert high", bOut, 9'h0F3);
    // R5 with hold: invert acts on held word
    nextCycle();
    holdCA = 1; holdCB = 1; cIn = 9'h000; parInv = 0;
    #5 check("R5 held no invert", aOut, 9'h1F3);
    parInv = 1;
    #1 check("R5 held invert", bOut, 9'h0F3);

    // Random phase
    for (int i = 0; i < 500; i++) begin
      nextCycle();
      selSrcB = 1'($urandom); selSrcC = 1'($urandom); parInv = 1'($urandom);
      oeAN = 1'($urandom); oeBN = 1'($urandom); oeCN = 1'($urandom);
      holdAC = 1'($urandom); holdCA = 1'($urandom);
      holdBC = 1'($urandom); holdCB = 1'($urandom);
      aIn = 9'($urandom); bIn = 9'($urandom); cIn = 9'($urandom);
      #5 checkModel("R2 R4 R5 A/B random", "R1 R3 C random");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule